// File: doc/BRIEF.md
# Eight-Channel Timer Register Bank

This block is the register front end for a group of eight countdown timer channels. A simple 32-bit request bus (valid, write, byte offset, write data) reaches per-channel count, reload and two match registers, a shared control word and a second general control word. The counting logic of each channel sits outside the bank. The bank drives each channel's configuration, reload and match values and a count-load strobe. It takes back the live count and the match-hit and zero-reached events, and turns those events into one level interrupt per channel.

The channel windows are split around a hole that holds the control words. When a control write changes a channel's enable bit together with its other bits, the bank orders the updates. A channel being switched off stops before it is reconfigured. A channel being switched on is configured first and starts one cycle later. Read data and an error pulse come back on the cycle after the request.

Top module: `tmr_regbank`

## Requirements
- R1: After reset, both control words read as zero, every channel's enable, clock-select, overflow-enable and pulse outputs are 0, the reload and match outputs are zero and every interrupt output is 0.
- R2: Channel c (0-based) owns a 16-byte window at (c)*16 for c<3 and at (c+1)*16 for c>=3. Word +0 is count, +4 reload, +8 match0 and +C match1. Reload and match writes read back and appear on that channel's output ports.
- R3: Offset 0x30 is the shared control word, with channel c's 4-bit field at bits [4c+3:4c]: bit 0 enable, bit 1 external clock, bit 2 overflow-interrupt enable, bit 3 pulse. Offset 0x34 is a second 32-bit word that reads back what was written.
- R4: Offsets 0x38, 0x3C, 0x90 and above, and any offset with bits [1:0] not zero, read as zero, change nothing when written, and raise the error pulse.
- R5: When a control write turns a channel's enable from 0 to 1, the other three bits take effect on the edge that samples the write, and the enable output rises one cycle later.
- R6: When a control write turns a channel's enable from 1 to 0, the enable output falls on the edge that samples the write, and the other three bits change one cycle later.
- R7: Only channels 4 to 7 (0-based) support pulse mode. A pulse bit written for channels 0 to 3 is stored as 0, their pulse outputs stay 0, and the write raises the error pulse.
- R8: Each read request gives a response valid pulse with its data exactly one cycle later. The error pulse, when raised, comes in that same cycle and lasts one cycle.
- R9: A count read returns the channel's live count input while the channel is enabled, and its reload value while it is disabled.
- R10: A count write pulses that channel's load strobe alone for one cycle, the cycle after the request, with the written value on the shared load-value output.
- R11: A channel's interrupt output toggles one cycle after a match-hit event, or after a zero event when its overflow enable is set, but only while the channel is enabled. Other events leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DW | Read response data |
| err_pulse | output | 1 | Illegal access or unsupported pulse request |
| ch_en_o | output | NCH | Channel run enable |
| ch_extclk_o | output | NCH | Channel external clock select |
| ch_ovfie_o | output | NCH | Channel overflow interrupt enable |
| ch_pulse_o | output | NCH | Channel pulse mode |
| ch_reload_o | output | NCH*DW | Packed reload values |
| ch_match0_o | output | NCH*DW | Packed first match values |
| ch_match1_o | output | NCH*DW | Packed second match values |
| ch_load_o | output | NCH | Count-load strobes |
| ch_load_val_o | output | DW | Value for a count load |
| ch_count_i | input | NCH*DW | Packed live counts |
| ch_hit_i | input | NCH | Match-hit events |
| ch_zero_i | input | NCH | Zero-reached events |
| irq_o | output | NCH | Per-channel interrupt levels |

## Verification
A wrong decode sends a write to the wrong window. That shows on the next reload or match port of the wrong channel, or in a read sweep of all 64 aligned offsets one cycle after each request. A sequencer stuck in its staged state shows as an enable or configuration output that lags, or moves early, on the edge after a control write, so each ordering case is sampled on both edges. A lost or extra interrupt toggle flips the level for good, so it is visible at once and stays visible until the next event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {AK_BAD, AK_SLOT, AK_CTRL, AK_CTRL2} acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [7:0] ch;
    logic [1:0] word;
  } acc_dec_t;

  // Slot arithmetic: lower windows map straight, one hole slot, upper windows shifted by one.
  function automatic acc_dec_t decode_off(input logic [15:0] off, input int lo_slots, input int nch);
    acc_dec_t d;
    int s;
    d.kind = AK_BAD;
    d.ch   = '0;
    d.word = off[3:2];
    s      = int'(off[15:4]);
    if (off[1:0] == 2'b00) begin
      if (s < lo_slots) begin
        d.kind = AK_SLOT;
        d.ch   = 8'(s);
      end else if (s == lo_slots) begin
        if (off[3:2] == 2'd0)      d.kind = AK_CTRL;
        else if (off[3:2] == 2'd1) d.kind = AK_CTRL2;
      end else if (s <= nch) begin
        d.kind = AK_SLOT;
        d.ch   = 8'(s - 1);
      end
    end
    return d;
  endfunction

  function automatic logic irq_next(input logic cur, input logic en, input logic hit,
                                    input logic zero, input logic ovf);
    return cur ^ (en & (hit | (zero & ovf)));
  endfunction

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NCH      = 8,
  parameter int LO_SLOTS = 3
) (
  input  logic [AW-1:0] addr,
  output acc_dec_t      dec
);
  always_comb dec = decode_off(16'(addr), LO_SLOTS, NCH);
endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [3:0] fld,
  output logic       en_o,
  output logic [2:0] cfg_o
);
  logic       stg_vld, stg_en;
  logic [2:0] stg_cfg;
  logic       turning_on, turning_off;

  assign turning_on  = wr & fld[0] & ~en_o;
  assign turning_off = wr & ~fld[0] & en_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o    <= 1'b0;
      cfg_o   <= '0;
      stg_vld <= 1'b0;
      stg_en  <= 1'b0;
      stg_cfg <= '0;
    end else if (turning_on) begin
      cfg_o   <= fld[3:1];
      stg_vld <= 1'b1;
      stg_en  <= 1'b1;
    end else if (turning_off) begin
      en_o    <= 1'b0;
      stg_vld <= 1'b1;
      stg_en  <= 1'b0;
      stg_cfg <= fld[3:1];
    end else if (wr) begin
      en_o    <= fld[0];
      cfg_o   <= fld[3:1];
      stg_vld <= 1'b0;
    end else if (stg_vld) begin
      if (stg_en) en_o  <= 1'b1;
      else        cfg_o <= stg_cfg;
      stg_vld <= 1'b0;
    end
  end

  // R5: configuration is already settled on the edge the enable rises
  a_r5_cfg_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_o) |-> $stable(cfg_o));
  // R6: configuration is untouched on the edge the enable falls
  a_r6_stop_before_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_o) |-> $stable(cfg_o));
endmodule

// File: rtl/tmr_chan_slot.sv
module tmr_chan_slot
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    word,
  input  logic [DW-1:0] wdata,
  input  logic          en,
  input  logic          ovf_en,
  input  logic          hit_i,
  input  logic          zero_i,
  output logic [DW-1:0] reload_o,
  output logic [DW-1:0] match0_o,
  output logic [DW-1:0] match1_o,
  output logic          load_o,
  output logic          irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_o <= '0;
      match0_o <= '0;
      match1_o <= '0;
      load_o   <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      load_o <= wr_en && (word == 2'd0);
      if (wr_en) begin
        case (word)
          2'd1:    reload_o <= wdata;
          2'd2:    match0_o <= wdata;
          2'd3:    match1_o <= wdata;
          default: ;
        endcase
      end
      irq_o <= irq_next(irq_o, en, hit_i, zero_i, ovf_en);
    end
  end

  // R11: the level moves only after a qualified event
  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_o) |-> $past(en && (hit_i || (zero_i && ovf_en))));
  // R10: a load strobe is always preceded by a count write
  a_r10_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> $past(wr_en && word == 2'd0));
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
  import tmr_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int NCH         = 8,
  parameter int LO_SLOTS    = 3,
  parameter int PULSE_FIRST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              err_pulse,
  output logic [NCH-1:0]    ch_en_o,
  output logic [NCH-1:0]    ch_extclk_o,
  output logic [NCH-1:0]    ch_ovfie_o,
  output logic [NCH-1:0]    ch_pulse_o,
  output logic [NCH*DW-1:0] ch_reload_o,
  output logic [NCH*DW-1:0] ch_match0_o,
  output logic [NCH*DW-1:0] ch_match1_o,
  output logic [NCH-1:0]    ch_load_o,
  output logic [DW-1:0]     ch_load_val_o,
  input  logic [NCH*DW-1:0] ch_count_i,
  input  logic [NCH-1:0]    ch_hit_i,
  input  logic [NCH-1:0]    ch_zero_i,
  output logic [NCH-1:0]    irq_o
);
  localparam int CW  = NCH * 4;
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  acc_dec_t         dec;
  logic [CW-1:0]    ctrl_q, ctrl_new;
  logic [DW-1:0]    ctrl2_q;
  logic [NCH-1:0]   low_pulse_req;
  logic             ctrl_wr, ctrl2_wr, slot_wr, bad_pulse, err_d;
  logic [CHW-1:0]   sel;
  logic [DW-1:0]    reload_a [NCH];
  logic [DW-1:0]    match0_a [NCH];
  logic [DW-1:0]    match1_a [NCH];
  logic [DW-1:0]    count_a  [NCH];
  logic [DW-1:0]    rd_mux;

  tmr_addr_dec #(.AW(AW), .NCH(NCH), .LO_SLOTS(LO_SLOTS)) dec_i (
    .addr (req_addr),
    .dec  (dec)
  );

  assign sel       = dec.ch[CHW-1:0];
  assign ctrl_wr   = req_valid & req_write & (dec.kind == AK_CTRL);
  assign ctrl2_wr  = req_valid & req_write & (dec.kind == AK_CTRL2);
  assign slot_wr   = req_valid & req_write & (dec.kind == AK_SLOT);
  assign bad_pulse = ctrl_wr & (|low_pulse_req);
  assign err_d     = req_valid & ((dec.kind == AK_BAD) | bad_pulse);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [3:0] fld;
    logic [2:0] cfg;
    if (c >= PULSE_FIRST) begin : g_pulse
      assign fld              = req_wdata[4*c +: 4];
      assign low_pulse_req[c] = 1'b0;
    end else begin : g_nopulse
      assign fld              = {1'b0, req_wdata[4*c +: 3]};
      assign low_pulse_req[c] = req_wdata[4*c+3];
    end
    assign ctrl_new[4*c +: 4] = fld;

    tmr_ctrl_seq seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctrl_wr),
      .fld   (fld),
      .en_o  (ch_en_o[c]),
      .cfg_o (cfg)
    );
    assign ch_extclk_o[c] = cfg[0];
    assign ch_ovfie_o[c]  = cfg[1];
    assign ch_pulse_o[c]  = cfg[2];

    tmr_chan_slot #(.DW(DW)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (slot_wr && (dec.ch == 8'(c))),
      .word     (dec.word),
      .wdata    (req_wdata),
      .en       (ch_en_o[c]),
      .ovf_en   (cfg[1]),
      .hit_i    (ch_hit_i[c]),
      .zero_i   (ch_zero_i[c]),
      .reload_o (reload_a[c]),
      .match0_o (match0_a[c]),
      .match1_o (match1_a[c]),
      .load_o   (ch_load_o[c]),
      .irq_o    (irq_o[c])
    );
    assign ch_reload_o[c*DW +: DW] = reload_a[c];
    assign ch_match0_o[c*DW +: DW] = match0_a[c];
    assign ch_match1_o[c*DW +: DW] = match1_a[c];
    assign count_a[c]              = ch_count_i[c*DW +: DW];
  end

  always_comb begin
    rd_mux = '0;
    case (dec.kind)
      AK_CTRL:  rd_mux = DW'(ctrl_q);
      AK_CTRL2: rd_mux = ctrl2_q;
      AK_SLOT: begin
        case (dec.word)
          2'd0:    rd_mux = ch_en_o[sel] ? count_a[sel] : reload_a[sel];
          2'd1:    rd_mux = reload_a[sel];
          2'd2:    rd_mux = match0_a[sel];
          default: rd_mux = match1_a[sel];
        endcase
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q        <= '0;
      ctrl2_q       <= '0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      err_pulse     <= 1'b0;
      ch_load_val_o <= '0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      err_pulse <= err_d;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
      if (ctrl_wr)  ctrl_q  <= ctrl_new;
      if (ctrl2_wr) ctrl2_q <= req_wdata;
      if (slot_wr && dec.word == 2'd0) ch_load_val_o <= req_wdata;
    end
  end

  // R8: a response only follows a read request
  a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  // R4: the error pulse only follows a request
  a_r4_err_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_valid));
  // R7: an unsupported pulse request is flagged on the next cycle
  a_r7_pulse_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pulse |=> err_pulse);
  // R7: channels without pulse support never show pulse mode
  a_r7_no_low_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_pulse_o & NCH'((1 << PULSE_FIRST) - 1)) == '0);
endmodule

// File: tb/tmr_regbank_tb.sv
module tmr_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]        req_addr = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic              rsp_valid, err_pulse;
  logic [DW-1:0]     rsp_rdata, ch_load_val_o;
  logic [NCH-1:0]    ch_en_o, ch_extclk_o, ch_ovfie_o, ch_pulse_o, ch_load_o, irq_o;
  logic [NCH*DW-1:0] ch_reload_o, ch_match0_o, ch_match1_o;
  logic [NCH*DW-1:0] ch_count_i = '0;
  logic [NCH-1:0]    ch_hit_i = '0, ch_zero_i = '0;

  int n_tests = 0, n_fail = 0;
  logic          got_rv, got_err;
  logic [DW-1:0] got_rd;
  logic [NCH-1:0] got_load;
  logic [DW-1:0] got_lval;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_regbank dut_i (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata, .err_pulse,
    .ch_en_o, .ch_extclk_o, .ch_ovfie_o, .ch_pulse_o,
    .ch_reload_o, .ch_match0_o, .ch_match1_o,
    .ch_load_o, .ch_load_val_o, .ch_count_i, .ch_hit_i, .ch_zero_i, .irq_o
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    got_rv = rsp_valid; got_rd = rsp_rdata; got_err = err_pulse;
    got_load = ch_load_o; got_lval = ch_load_val_o;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // Window base: lower three channels packed from zero, the rest one slot higher.
  function automatic logic [7:0] win(input int c, input int w);
    int s;
    s = (c < 3) ? c : c + 1;
    return 8'(s * 16 + w * 4);
  endfunction

  function automatic logic [DW-1:0] pat(input int c, input int w);
    return 32'h5A00_0000 + DW'(c * 4096 + w * 17 + 3);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    chk({ch_en_o, ch_extclk_o, ch_ovfie_o, ch_pulse_o, irq_o} == '0, "R1 channel outputs", 32'({ch_en_o, irq_o}), 0);
    chk(ch_reload_o == '0 && ch_match0_o == '0 && ch_match1_o == '0, "R1 values", ch_reload_o[31:0], 0);
    bus(0, 8'h30, 0); chk(got_rd == 0, "R1 ctrl", got_rd, 0);
    bus(0, 8'h34, 0); chk(got_rd == 0, "R1 ctrl2", got_rd, 0);

    // R2 / R10: write every channel register
    for (int c = 0; c < NCH; c++) begin
      for (int w = 0; w < 4; w++) begin
        bus(1, win(c, w), pat(c, w));
        if (w == 0) begin
          chk(got_load == NCH'(1 << c), "R10 strobe", 32'(got_load), 32'(1 << c));
          chk(got_lval == pat(c, 0), "R10 value", got_lval, pat(c, 0));
          @(posedge clk); #1;
          chk(ch_load_o == '0, "R10 one cycle", 32'(ch_load_o), 0);
        end
      end
      chk(ch_reload_o[c*DW +: DW] == pat(c, 1), "R2 reload port", ch_reload_o[c*DW +: DW], pat(c, 1));
      chk(ch_match0_o[c*DW +: DW] == pat(c, 2), "R2 match0 port", ch_match0_o[c*DW +: DW], pat(c, 2));
      chk(ch_match1_o[c*DW +: DW] == pat(c, 3), "R2 match1 port", ch_match1_o[c*DW +: DW], pat(c, 3));
    end

    // R2 / R4 / R8 / R9: read sweep of every aligned offset, all channels disabled
    for (int off = 0; off < 256; off += 4) begin
      logic [DW-1:0] e;
      bit bad;
      bad = 1'b0; e = '0;
      if (off == 'h30 || off == 'h34) e = '0;
      else if (off < 'h30 || (off >= 'h40 && off < 'h90)) begin
        int c, w;
        c = (off < 'h30) ? off / 16 : off / 16 - 1;
        w = (off % 16) / 4;
        e = pat(c, (w == 0) ? 1 : w);
      end else bad = 1'b1;
      bus(0, 8'(off), 0);
      chk(got_rv, "R8 rsp_valid", 32'(got_rv), 1);
      chk(got_rd == e, "R2 R9 R4 readback", got_rd, e);
      chk(got_err == bad, "R4 err flag", 32'(got_err), 32'(bad));
      @(posedge clk); #1;
      chk(!rsp_valid && !err_pulse, "R8 one cycle", 32'({rsp_valid, err_pulse}), 0);
    end

    // R3: second control word
    bus(1, 8'h34, 32'hDEAD_BEEF); bus(0, 8'h34, 0);
    chk(got_rd == 32'hDEAD_BEEF, "R3 ctrl2", got_rd, 32'hDEAD_BEEF);

    // R4: illegal writes change nothing
    bus(1, 8'h38, 32'hFFFF_FFFF); chk(got_err, "R4 err 0x38", 32'(got_err), 1);
    bus(1, 8'h94, 32'h1234_5678); chk(got_err, "R4 err 0x94", 32'(got_err), 1);
    bus(1, 8'h15, 32'h1234_5678); chk(got_err, "R4 err unaligned", 32'(got_err), 1);
    bus(0, 8'h38, 0); chk(got_rd == 0, "R4 read 0x38", got_rd, 0);
    bus(0, win(1, 1), 0); chk(got_rd == pat(1, 1), "R4 reload kept", got_rd, pat(1, 1));
    bus(0, 8'h30, 0); chk(got_rd == 0, "R4 ctrl kept", got_rd, 0);

    // R5: enable ch5 with all other bits
    bus(1, 8'h30, 32'h00F0_0000);
    chk(!got_err, "R7 legal pulse", 32'(got_err), 0);
    chk(ch_en_o[5] == 0 && ch_extclk_o[5] && ch_ovfie_o[5] && ch_pulse_o[5], "R5 cfg first",
        32'({ch_en_o[5], ch_extclk_o[5], ch_ovfie_o[5], ch_pulse_o[5]}), 32'b0111);
    @(posedge clk); #1;
    chk(ch_en_o == 8'h20, "R5 enable later", 32'(ch_en_o), 32'h20);
    bus(0, 8'h30, 0); chk(got_rd == 32'h00F0_0000, "R3 ctrl readback", got_rd, 32'h00F0_0000);

    // R9: enabled count read follows live count
    ch_count_i[5*DW +: DW] = 32'h0BAD_C0DE;
    bus(0, win(5, 0), 0); chk(got_rd == 32'h0BAD_C0DE, "R9 live count", got_rd, 32'h0BAD_C0DE);

    // R6: disable ch5, clear other bits
    bus(1, 8'h30, 32'h0);
    chk(ch_en_o[5] == 0 && ch_extclk_o[5] && ch_pulse_o[5], "R6 stop first",
        32'({ch_en_o[5], ch_extclk_o[5], ch_pulse_o[5]}), 32'b011);
    @(posedge clk); #1;
    chk(ch_extclk_o == 0 && ch_ovfie_o == 0 && ch_pulse_o == 0, "R6 cfg later",
        32'({ch_extclk_o, ch_ovfie_o, ch_pulse_o}), 0);
    bus(0, win(5, 0), 0); chk(got_rd == pat(5, 1), "R9 disabled reload", got_rd, pat(5, 1));

    // R7: pulse request on a channel without pulse support
    bus(1, 8'h30, 32'h0000_000F);
    chk(got_err, "R7 err", 32'(got_err), 1);
    @(posedge clk); #1;
    chk(ch_pulse_o[0] == 0 && ch_en_o[0], "R7 pulse ignored", 32'({ch_pulse_o[0], ch_en_o[0]}), 32'b01);
    bus(0, 8'h30, 0); chk(got_rd == 32'h7, "R7 stored", got_rd, 32'h7);

    // R11: interrupt toggling on ch0
    bus(1, 8'h30, 32'h1);
    @(negedge clk) ch_zero_i[0] = 1'b1; @(negedge clk) ch_zero_i[0] = 1'b0;
    chk(irq_o == 0, "R11 zero without ovf", 32'(irq_o), 0);
    @(negedge clk) ch_hit_i[0] = 1'b1; @(negedge clk) ch_hit_i[0] = 1'b0;
    chk(irq_o == 8'h01, "R11 hit toggles", 32'(irq_o), 1);
    bus(1, 8'h30, 32'h5);
    @(negedge clk) ch_zero_i[0] = 1'b1; @(negedge clk) ch_zero_i[0] = 1'b0;
    chk(irq_o == 0, "R11 zero with ovf", 32'(irq_o), 0);
    @(negedge clk) ch_hit_i[1] = 1'b1; @(negedge clk) ch_hit_i[1] = 1'b0;
    chk(irq_o == 0, "R11 disabled ignored", 32'(irq_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule